// File: doc/BRIEF.md
# DRAM refresh scheduler

This block keeps every row of an asynchronous DRAM alive by issuing CAS-before-RAS refresh cycles, in which the device's own row counter picks the row. No address is needed. A free-running interval timer adds one owed refresh each time a slot of the retention window elapses. The slot length is the window length divided by the number of rows, in clock cycles. When refreshes are owed, the block raises a request to the access sequencer. Once the request is granted, the block takes over the strobes and runs a complete cycle: CAS low first, then RAS low, then precharge with both strobes high. WE is held high throughout.

There are two operating styles, chosen by a strap input:
- **Distributed:** a single owed refresh is enough to ask for the bus, and each grant buys one cycle.
- **Burst:** the request waits until a whole window's worth of refreshes is owed. One grant then runs cycles back to back until nothing is owed.

While the sequencer is busy, owed refreshes queue up. Past a parameterised backlog the block also raises an urgent flag.

A self-refresh request takes priority over a pending grant. The block starts a CBR cycle and keeps RAS low. Once the self-refresh entry time has passed, it reports that the device is in self refresh. When the request is released, both strobes go high for the self-refresh precharge time. What happens next depends on the style:
- **Distributed:** the owed count is cleared and the timer restarts, because no catch-up is needed.
- **Burst:** a full window of refreshes is marked as owed, which forces an immediate full burst.

States:
- `ST_IDLE` (strobes released)
- `ST_CAS` (CAS low, RAS high)
- `ST_RAS` (both low)
- `ST_PRE` (precharge)
- `ST_SR_CAS` (self-refresh CAS lead)
- `ST_SR_HOLD` (RAS held low, entry time counting)
- `ST_SR_ACT` (in self refresh)
- `ST_SR_EXIT` (exit precharge)

Transitions:
- **grant:** `ST_IDLE` to `ST_CAS`.
- **sr_enter:** `ST_IDLE` to `ST_SR_CAS`.
- **lead_done:** `ST_CAS` to `ST_RAS`.
- **low_done:** `ST_RAS` to `ST_PRE`.
- **chain:** `ST_PRE` to `ST_CAS`, taken in a burst while more than one refresh is owed.
- **finish:** `ST_PRE` to `ST_IDLE`.
- **sr_lead_done:** `ST_SR_CAS` to `ST_SR_HOLD`.
- **sr_entered:** `ST_SR_HOLD` to `ST_SR_ACT`.
- **sr_release:** `ST_SR_HOLD` or `ST_SR_ACT` to `ST_SR_EXIT`.
- **sr_done:** `ST_SR_EXIT` to `ST_IDLE`.

Top module: `refresh_scheduler`

## Requirements
- R1: While reset is applied and immediately after it, `ras_n`, `cas_n` and `we_n` are 1, and `own_bus`, `ref_req`, `ref_urgent` and `sr_active` are 0.
- R2: The interval timer starts from zero at reset release. In distributed mode (`burst_mode`=0), `ref_req` is 0 for the first INTERVAL-1 clock edges and becomes 1 after edge INTERVAL, where INTERVAL = CLK_KHZ*WINDOW_MS/ROWS.
- R3: A grant is taken on an edge where `ref_req` and `ref_gnt` are both 1. The following cycles are:
  - T_CSR cycles with `cas_n`=0 and `ras_n`=1;
  - then T_RAS cycles with both strobes 0;
  - then T_RP cycles with both strobes 1.

  `own_bus` is 1 and `we_n` is 1 throughout, and `ras_n` never falls unless `cas_n` was already 0 in the cycle before.
- R4: Each completed refresh cycle lowers the owed count by one. `ref_req` is 1 only while the block is idle, is not being asked for self refresh, and the owed count has reached the threshold. The threshold is 1 in distributed mode and ROWS in burst mode.
- R5: `ref_urgent` is 1 while the owed count is at least MAX_BACKLOG in distributed mode, or at least ROWS+MAX_BACKLOG in burst mode.
- R6: In burst mode, one grant runs refresh cycles back to back, each new cycle following the previous precharge directly. The chain continues until a precharge ends with at most one refresh owed. No request is raised while fewer than ROWS refreshes are owed.
- R7: When the block is idle and `sr_req` is 1, it starts self refresh, ignoring any grant in that cycle. CAS goes low for T_CSR cycles, then RAS goes low. `sr_active` becomes 1 after RAS has been low for T_RASS cycles, and both strobes stay low while it is 1.
- R8: While `sr_active` is 1, a 0 on `sr_req` raises both strobes and clears `sr_active` on the next edge. The strobes then stay high, with `own_bus` still 1, for T_RPS cycles.
- R9: The timer is held at zero during self refresh and restarts when the bus is released.
  - In distributed mode, leaving self refresh clears the owed count, so `ref_req` is 0 until a further INTERVAL edges have passed.
  - In burst mode, leaving self refresh sets the owed count to ROWS, so `ref_req` is 1 as soon as the bus is released.
- R10: `ref_gnt` has no effect while `ref_req` is 0: `own_bus` stays 0.
- R11: At the end of every group of ROWS intervals since reset or since the last self-refresh exit, completed refreshes plus refreshes still owed are at least the number of intervals elapsed.
- R12: A timer interval that ends in the same cycle as a completed refresh leaves the owed count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_mode | input | 1 | Strap: 1 selects burst refresh, 0 distributed refresh |
| sr_req | input | 1 | Level request to enter and stay in self refresh |
| ref_gnt | input | 1 | Grant from the access sequencer |
| ref_req | output | 1 | Refresh request to the access sequencer |
| ref_urgent | output | 1 | Backlog has reached its limit |
| own_bus | output | 1 | The block is driving the strobes |
| cas_n | output | 1 | Column strobe, active low |
| ras_n | output | 1 | Row strobe, active low |
| we_n | output | 1 | Write enable, held high while refreshing |
| sr_active | output | 1 | The device is in self refresh |

## Verification
Two events can land on the same clock edge: the interval timer adding an owed refresh, and a completed CBR cycle retiring one. The bench provokes this by placing a grant exactly seven cycles before the end of a timer interval, so the final precharge cycle coincides with the tick. With a backlog limit of two, it then judges the owed count through `ref_urgent`: the flag must stay high across that edge, drop only after the next cycle completes, and `ref_req` must fall only after one more cycle. A second overlap, self-refresh request and grant in the same idle cycle, is judged by `sr_active` rising after the entry time rather than a plain precharge ending the sequence.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CAS,
        ST_RAS,
        ST_PRE,
        ST_SR_CAS,
        ST_SR_HOLD,
        ST_SR_ACT,
        ST_SR_EXIT
    } rs_state_e;

    // Bits needed to hold values 0 .. n-1 (at least one bit).
    function automatic int cbits(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/refsched_timer.sv
module refsched_timer #(
    parameter int INTERVAL = 781
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic tick
);
    localparam int TW = refsched_pkg::cbits(INTERVAL);
    localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (hold)        cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = !hold && (cnt == LAST);
endmodule

// File: rtl/refsched_ledger.sv
module refsched_ledger #(
    parameter int ROWS = 4096,
    parameter int PW   = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          done,
    input  logic          clear,
    input  logic          load_full,
    output logic [PW-1:0] pend
);
    localparam logic [PW-1:0] P_MAX  = '1;
    localparam logic [PW-1:0] P_ROWS = PW'(ROWS);

    logic [PW-1:0] nxt_p;

    always_comb begin
        nxt_p = pend;
        if (tick && pend != P_MAX) nxt_p = nxt_p + 1'b1;
        if (done && pend != '0)    nxt_p = nxt_p - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         pend <= '0;
        else if (clear)     pend <= '0;
        else if (load_full) pend <= P_ROWS;
        else                pend <= nxt_p;
    end
endmodule

// File: rtl/refsched_fsm.sv
module refsched_fsm
    import refsched_pkg::*;
#(
    parameter int T_CSR  = 1,
    parameter int T_RAS  = 3,
    parameter int T_RP   = 2,
    parameter int T_RASS = 5000,
    parameter int T_RPS  = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic due,
    input  logic more,
    input  logic ref_gnt,
    input  logic sr_req,
    input  logic burst_mode,
    output logic cas_n,
    output logic ras_n,
    output logic own_bus,
    output logic sr_active,
    output logic idle,
    output logic sr_phase,
    output logic done,
    output logic exit_done
);
    localparam int TMAX = imax(imax(imax(T_CSR, T_RAS), imax(T_RP, T_RASS)), T_RPS);
    localparam int CW   = cbits(TMAX);
    localparam logic [CW-1:0] C_CSR  = CW'(T_CSR - 1);
    localparam logic [CW-1:0] C_RAS  = CW'(T_RAS - 1);
    localparam logic [CW-1:0] C_RP   = CW'(T_RP - 1);
    localparam logic [CW-1:0] C_RASS = CW'(T_RASS - 1);
    localparam logic [CW-1:0] C_RPS  = CW'(T_RPS - 1);

    rs_state_e     state, nxt;
    logic [CW-1:0] cnt;
    logic          burst_run;

    // state register, phase counter and burst chain flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            burst_run <= 1'b0;
        end else begin
            state <= nxt;
            cnt   <= (nxt != state) ? '0 : cnt + 1'b1;
            if (state == ST_IDLE && nxt == ST_CAS) burst_run <= burst_mode;
            else if (nxt == ST_IDLE)               burst_run <= 1'b0;
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (sr_req)              nxt = ST_SR_CAS;   // sr_enter
                else if (due && ref_gnt) nxt = ST_CAS;      // grant
            end
            ST_CAS:     if (cnt == C_CSR) nxt = ST_RAS;     // lead_done
            ST_RAS:     if (cnt == C_RAS) nxt = ST_PRE;     // low_done
            ST_PRE:     if (cnt == C_RP)  nxt = (burst_run && more) ? ST_CAS : ST_IDLE;
            ST_SR_CAS:  if (cnt == C_CSR) nxt = ST_SR_HOLD; // sr_lead_done
            ST_SR_HOLD: begin
                if (!sr_req)            nxt = ST_SR_EXIT;   // sr_release
                else if (cnt == C_RASS) nxt = ST_SR_ACT;    // sr_entered
            end
            ST_SR_ACT:  if (!sr_req)      nxt = ST_SR_EXIT; // sr_release
            ST_SR_EXIT: if (cnt == C_RPS) nxt = ST_IDLE;    // sr_done
            default:                      nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cas_n     = 1'b1;
        ras_n     = 1'b1;
        own_bus   = 1'b1;
        sr_active = 1'b0;
        idle      = 1'b0;
        sr_phase  = 1'b0;
        done      = 1'b0;
        exit_done = 1'b0;
        unique case (state)
            ST_IDLE: begin
                own_bus = 1'b0;
                idle    = 1'b1;
            end
            ST_CAS:  cas_n = 1'b0;
            ST_RAS: begin
                cas_n = 1'b0;
                ras_n = 1'b0;
            end
            ST_PRE:  done = (cnt == C_RP);
            ST_SR_CAS: begin
                cas_n    = 1'b0;
                sr_phase = 1'b1;
            end
            ST_SR_HOLD: begin
                cas_n    = 1'b0;
                ras_n    = 1'b0;
                sr_phase = 1'b1;
            end
            ST_SR_ACT: begin
                cas_n     = 1'b0;
                ras_n     = 1'b0;
                sr_phase  = 1'b1;
                sr_active = 1'b1;
            end
            ST_SR_EXIT: begin
                sr_phase  = 1'b1;
                exit_done = (cnt == C_RPS);
            end
            default: own_bus = 1'b0;
        endcase
    end
endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler #(
    parameter int CLK_KHZ     = 50000,
    parameter int WINDOW_MS   = 64,
    parameter int ROWS        = 4096,
    parameter int MAX_BACKLOG = 8,
    parameter int T_CSR       = 1,
    parameter int T_RAS       = 3,
    parameter int T_RP        = 2,
    parameter int T_RASS      = 5000,
    parameter int T_RPS       = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic burst_mode,
    input  logic sr_req,
    input  logic ref_gnt,
    output logic ref_req,
    output logic ref_urgent,
    output logic own_bus,
    output logic cas_n,
    output logic ras_n,
    output logic we_n,
    output logic sr_active
);
    localparam int INTERVAL = CLK_KHZ * WINDOW_MS / ROWS;
    localparam int PW       = refsched_pkg::cbits(ROWS + MAX_BACKLOG + 1);
    localparam logic [PW-1:0] P_ONE   = PW'(1);
    localparam logic [PW-1:0] P_ROWS  = PW'(ROWS);
    localparam logic [PW-1:0] P_URG_D = PW'(MAX_BACKLOG);
    localparam logic [PW-1:0] P_URG_B = PW'(ROWS + MAX_BACKLOG);

    logic          tick, done, exit_done, idle, sr_phase;
    logic          due, more;
    logic [PW-1:0] pend;

    refsched_timer #(.INTERVAL(INTERVAL)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .hold (sr_phase),
        .tick (tick)
    );

    refsched_ledger #(.ROWS(ROWS), .PW(PW)) u_ledger (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .done     (done),
        .clear    (exit_done && !burst_mode),
        .load_full(exit_done && burst_mode),
        .pend     (pend)
    );

    assign due        = burst_mode ? (pend >= P_ROWS) : (pend != '0);
    assign more       = pend > P_ONE;
    assign ref_urgent = pend >= (burst_mode ? P_URG_B : P_URG_D);
    assign ref_req    = due && idle && !sr_req;
    assign we_n       = 1'b1;

    refsched_fsm #(
        .T_CSR (T_CSR),
        .T_RAS (T_RAS),
        .T_RP  (T_RP),
        .T_RASS(T_RASS),
        .T_RPS (T_RPS)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .due       (due),
        .more      (more),
        .ref_gnt   (ref_gnt),
        .sr_req    (sr_req),
        .burst_mode(burst_mode),
        .cas_n     (cas_n),
        .ras_n     (ras_n),
        .own_bus   (own_bus),
        .sr_active (sr_active),
        .idle      (idle),
        .sr_phase  (sr_phase),
        .done      (done),
        .exit_done (exit_done)
    );
endmodule

// File: rtl/refsched_chk.sv
module refsched_chk #(
    parameter int ROWS = 4096,
    parameter int PW   = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sr_req,
    input logic          ref_gnt,
    input logic          ref_req,
    input logic          own_bus,
    input logic          cas_n,
    input logic          ras_n,
    input logic          sr_active,
    input logic          tick,
    input logic          done,
    input logic          exit_done,
    input logic [PW-1:0] pend
);
    logic [31:0] ticks, dones;
    logic        win_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ticks   <= '0;
            dones   <= '0;
            win_end <= 1'b0;
        end else if (exit_done) begin
            ticks   <= '0;
            dones   <= '0;
            win_end <= 1'b0;
        end else begin
            ticks   <= ticks + 32'(tick);
            dones   <= dones + 32'(done);
            win_end <= tick && (((ticks + 32'd1) % 32'(ROWS)) == 32'd0);
        end
    end

    AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_n && $past(!cas_n))); // R3

    AST_SR_STROBES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        sr_active |-> (!ras_n && !cas_n)); // R7

    AST_SR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_active && !sr_req) |=> (!sr_active && ras_n && cas_n)); // R8

    AST_NO_UNASKED_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(own_bus) |-> ($past(sr_req) || $past(ref_gnt && ref_req))); // R10

    AST_WINDOW_COVERED: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |-> ((dones + 32'(pend)) >= ticks)); // R11
endmodule

bind refresh_scheduler refsched_chk #(.ROWS(ROWS), .PW(PW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sr_req   (sr_req),
    .ref_gnt  (ref_gnt),
    .ref_req  (ref_req),
    .own_bus  (own_bus),
    .cas_n    (cas_n),
    .ras_n    (ras_n),
    .sr_active(sr_active),
    .tick     (tick),
    .done     (done),
    .exit_done(exit_done),
    .pend     (pend)
);

// File: tb/refresh_scheduler_bench.sv
module refresh_scheduler_bench;
    localparam int ROWS = 4;       // with CLK_KHZ=5, WINDOW_MS=16: INTERVAL = 20

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic burst_mode = 1'b0, sr_req = 1'b0, ref_gnt = 1'b0;
    logic ref_req, ref_urgent, own_bus, cas_n, ras_n, we_n, sr_active;
    int   cyc;
    int   n_run = 0, n_fail = 0;

    always #10 clk = ~clk;

    refresh_scheduler #(
        .CLK_KHZ(5), .WINDOW_MS(16), .ROWS(ROWS), .MAX_BACKLOG(2),
        .T_CSR(2), .T_RAS(3), .T_RP(2), .T_RASS(5), .T_RPS(4)
    ) u_refresh_scheduler (
        .clk(clk), .rst_n(rst_n), .burst_mode(burst_mode), .sr_req(sr_req),
        .ref_gnt(ref_gnt), .ref_req(ref_req), .ref_urgent(ref_urgent),
        .own_bus(own_bus), .cas_n(cas_n), .ras_n(ras_n), .we_n(we_n),
        .sr_active(sr_active)
    );

    always @(posedge clk or negedge rst_n)
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;

    // {ref_gnt to drive, own_bus, ras_n, cas_n, ref_req}, cycles 20..28
    localparam logic [4:0] SEQ [0:8] = '{
        5'b1_0111, 5'b0_1100, 5'b0_1100, 5'b0_1000, 5'b0_1000,
        5'b0_1000, 5'b0_1110, 5'b0_1110, 5'b0_0110
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
        end
    endtask

    task automatic at(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic do_reset(input logic burst);
        rst_n = 1'b0; ref_gnt = 1'b0; sr_req = 1'b0; burst_mode = burst;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic report;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        int falls, gaps;
        logic prev;
        // ---- distributed mode ----
        @(negedge clk);
        check("R1 strobes in reset", {ras_n, cas_n, we_n}, 3'b111);
        do_reset(1'b0);
        check("R1 strobes", {ras_n, cas_n, we_n}, 3'b111);
        check("R1 flags", {own_bus, ref_req, ref_urgent, sr_active}, 4'b0000);
        at(19); check("R2 no request yet", ref_req, 1'b0);
        for (int i = 0; i < 9; i++) begin
            at(20 + i);
            check("R3 R4 strobe table", {own_bus, ras_n, cas_n, ref_req}, SEQ[i][3:0]);
            check("R3 we_n high", we_n, 1'b1);
            ref_gnt = SEQ[i][4];
        end
        at(59); check("R5 below backlog", ref_urgent, 1'b0);
        at(60); check("R5 backlog reached", {ref_urgent, ref_req}, 2'b11);
        at(72); ref_gnt = 1'b1;
        at(73); ref_gnt = 1'b0;
        at(79); check("R5 still urgent", ref_urgent, 1'b1);
        at(80); check("R12 tick with completion", {ref_urgent, ref_req, own_bus}, 3'b110);
        ref_gnt = 1'b1;
        at(81); ref_gnt = 1'b0;
        at(88); check("R4 R5 one retired", {ref_urgent, ref_req, own_bus}, 3'b010);
        ref_gnt = 1'b1;
        at(89); ref_gnt = 1'b0;
        at(96); check("R4 nothing owed", {ref_req, own_bus}, 2'b00);
        ref_gnt = 1'b1;
        for (int c = 97; c <= 99; c++) begin
            at(c); check("R10 grant without request", own_bus, 1'b0);
        end
        ref_gnt = 1'b0;
        at(100); check("R2 next interval", ref_req, 1'b1);
        sr_req = 1'b1; ref_gnt = 1'b1;
        at(101); ref_gnt = 1'b0;
        check("R7 self refresh lead", {own_bus, ras_n, cas_n}, 3'b110);
        at(107); check("R7 before entry time", {sr_active, ras_n, cas_n}, 3'b000);
        at(108); check("R7 entered", {sr_active, ras_n, cas_n}, 3'b100);
        at(110); sr_req = 1'b0;
        at(111); check("R8 exit strobes", {sr_active, own_bus, ras_n, cas_n}, 4'b0111);
        at(114); check("R8 exit precharge", own_bus, 1'b1);
        at(115); check("R9 distributed cleared", {own_bus, ref_req}, 2'b00);
        at(134); check("R9 timer restarted", ref_req, 1'b0);
        at(135); check("R9 first interval after exit", ref_req, 1'b1);

        // ---- burst mode ----
        do_reset(1'b1);
        at(79); check("R6 below full window", ref_req, 1'b0);
        at(80); check("R6 full window owed", ref_req, 1'b1);
        ref_gnt = 1'b1;
        at(81); ref_gnt = 1'b0;
        falls = 0; gaps = 0; prev = 1'b1;
        for (int c = 81; c <= 115; c++) begin
            at(c);
            if (!own_bus) gaps++;
            if (prev && !ras_n) falls++;
            prev = ras_n;
        end
        check("R6 bus held through burst", gaps, 0);
        check("R6 cycles in burst", falls, 5);
        at(116); check("R6 burst finished", {own_bus, ref_req}, 2'b00);
        at(120); check("R6 single owed no request", ref_req, 1'b0);
        sr_req = 1'b1;
        at(128); check("R7 burst self refresh", sr_active, 1'b1);
        at(130); sr_req = 1'b0;
        at(134); check("R8 burst exit precharge", {own_bus, ras_n, cas_n}, 3'b111);
        at(135); check("R9 burst catch-up request", {own_bus, ref_req}, 2'b01);
        report;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: run hung");
        report;
    end
endmodule